// File: doc/BRIEF.md
# Temperature conversion host sequencer

This block is the host side of a serial link to a multichannel converter with an on-die temperature sensor. When `start_i` arrives in idle, it runs one 16-clock frame that sets the write bit and loads a configuration that selects the temperature channel. The converter begins the conversion when chip select falls for that frame and drives its busy line high. The sequencer synchronizes busy and waits for it to drop. It then holds the bus quiet for a minimum settling gap and runs a read frame that carries a zero write bit. It splits the returned word into a 4-bit channel tag and a 12-bit result. A `done_o` pulse reports the outcome with a status code.

The controller has five states. IDLE goes to WRITE on start, but only while busy is low. WRITE goes to WAIT when its frame ends. WAIT goes to GAP when busy is low, or back to IDLE with a timeout status when the timeout window runs out first. GAP goes to READ when the settling gap has elapsed. READ goes to IDLE when its frame ends, with status OK or INVALID. The gap and timeout lengths are computed from the system clock frequency parameter. The serial clock rate is set at run time through `div_i`.

Top module: `tconv_seq`

## Requirements
- R1: After reset `cs_n_o` and `sclk_o` are high, `done_o` is low and `status_o` is 00.
- R2: Each frame holds `cs_n_o` low for exactly 16 falling edges of `sclk_o`. Each half period of `sclk_o` lasts `div_i`+1 system cycles. `sclk_o` is high whenever `cs_n_o` is high.
- R3: The first frame of a sequence shifts out, MSB first on `din_o`, the word {1'b1, CFG}, where bit 15 is the write bit. `din_o` changes only on rising edges of `sclk_o`, so it is stable at every falling edge.
- R4: The falling edge of `cs_n_o` for the read frame comes at least GAP_CYC = ceil(GAP_NS·CLK_KHZ/10^6) system cycles after `busy_i` falls. No frame runs while the sequencer waits for busy or counts the gap.
- R5: The read frame shifts out sixteen zeros, so its write bit (bit 15) is 0. No frame whose chip select falls while the synchronized busy is high carries write bit 1.
- R6: The read frame captures `dout_i` on each falling edge of `sclk_o`, MSB first. One cycle after the frame ends, `done_o` pulses with `tag_o` = bits 15:12, `value_o` = bits 11:0 and `status_o` = 00 (OK).
- R7: A read word of all ones ends the sequence with `status_o` = 10 (INVALID), and `tag_o`/`value_o` keep their previous values.
- R8: If busy is still high TO_CYC = TIMEOUT_US·CLK_KHZ/1000 cycles after the write frame starts, `done_o` pulses with `status_o` = 01 (TIMEOUT), no read frame runs, and the sequencer returns to idle.
- R9: `start_i` has no effect while a sequence is running. `done_o` is high for exactly one cycle per sequence.
- R10: A `start_i` in idle while the synchronized busy is high launches no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a temperature sequence |
| div_i | input | DIV_W | SCLK half period minus one, in system cycles |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 OK, 01 TIMEOUT, 10 INVALID |
| tag_o | output | 4 | Channel tag of the last valid result |
| value_o | output | 12 | Last valid 12-bit result |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| busy_i | input | 1 | Converter busy line, asynchronous |

## Verification
The bench builds the block with CLK_KHZ = 50000, GAP_NS = 100 and TIMEOUT_US = 4, which gives a 5-cycle gap and a 200-cycle timeout window. With these values a timed-out busy period is reached in a few hundred cycles. It also sets DIV_W = 4 and sweeps every divider value from 0 to 3 against several response words, so each SCLK half-period length is measured against the converter model. The same configuration reaches the invalid all-ones word, the timeout with busy still held high, and start requests made both during a sequence and while busy blocks the idle state.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
    localparam int FRAME_BITS = 16;
    localparam int TAG_BITS   = 4;
    localparam int VAL_BITS   = FRAME_BITS - TAG_BITS;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_WAIT,
        S_GAP,
        S_READ
    } seq_state_t;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_TIMEOUT = 2'b01,
        ST_INVALID = 2'b10
    } seq_status_t;
endpackage

// File: rtl/tconv_sync.sv
module tconv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_one
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b1;
                else        q <= d_i;
            end
            assign q_o = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], d_i};
            end
            assign q_o = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tconv_timer.sv
module tconv_timer #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (!run_i)               cnt <= '0;
        else if (cnt != CW'(LIMIT))    cnt <= cnt + 1'b1;
    end

    assign expired_o = (cnt == CW'(LIMIT));

    // R4 / R8: once reached, the window stays expired while it keeps running
    a_r8_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && run_i) |=> expired_o);
endmodule

// File: rtl/tconv_frame.sv
module tconv_frame
    import tconv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go_i,
    input  logic [FRAME_BITS-1:0] word_i,
    input  logic [DIV_W-1:0]      div_i,
    input  logic                  dout_i,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic                  din_o,
    output logic [FRAME_BITS-1:0] rx_o,
    output logic                  done_o
);
    localparam int EDGES = 2 * FRAME_BITS;
    localparam int EW    = $clog2(EDGES);

    logic                  active;
    logic [DIV_W-1:0]      ph;
    logic [DIV_W-1:0]      div_q;
    logic [EW-1:0]         ed;
    logic [FRAME_BITS-1:0] tx;
    logic                  edge_now;
    logic                  last_edge;

    assign edge_now  = active && (ph == div_q);
    assign last_edge = (ed == EW'(EDGES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cs_n_o <= 1'b1;
            sclk_o <= 1'b1;
            ph     <= '0;
            div_q  <= '0;
            ed     <= '0;
            tx     <= '0;
            rx_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i && !active) begin
                active <= 1'b1;
                cs_n_o <= 1'b0;
                sclk_o <= 1'b1;
                ph     <= '0;
                ed     <= '0;
                div_q  <= div_i;
                tx     <= word_i;
            end else if (edge_now) begin
                ph <= '0;
                ed <= ed + 1'b1;
                if (!ed[0]) begin
                    sclk_o <= 1'b0;
                    rx_o   <= {rx_o[FRAME_BITS-2:0], dout_i};
                end else begin
                    sclk_o <= 1'b1;
                    tx     <= {tx[FRAME_BITS-2:0], 1'b0};
                    if (last_edge) begin
                        active <= 1'b0;
                        cs_n_o <= 1'b1;
                        done_o <= 1'b1;
                    end
                end
            end else if (active) begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign din_o = tx[FRAME_BITS-1];

    // checker: count SCLK falls inside the current frame
    logic                         sclk_d;
    logic [$clog2(EDGES+1)-1:0]   chk_falls;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b1;
            chk_falls <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (cs_n_o && sclk_d)            chk_falls <= '0;
            else if (sclk_d && !sclk_o)      chk_falls <= chk_falls + 1'b1;
        end
    end

    a_r2_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (chk_falls == FRAME_BITS));
    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    a_r3_din_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> $stable(din_o));
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
    import tconv_pkg::*;
#(
    parameter int                    CLK_KHZ     = 100000,
    parameter int                    GAP_NS      = 100,
    parameter int                    TIMEOUT_US  = 100,
    parameter int                    DIV_W       = 8,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [FRAME_BITS-2:0] CFG         = 15'h0420
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DIV_W-1:0]    div_i,
    output logic                done_o,
    output logic [1:0]          status_o,
    output logic [TAG_BITS-1:0] tag_o,
    output logic [VAL_BITS-1:0] value_o,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                din_o,
    input  logic                dout_i,
    input  logic                busy_i
);
    localparam int GAP_RAW = (GAP_NS * CLK_KHZ + 999_999) / 1_000_000;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int TO_RAW  = (TIMEOUT_US * CLK_KHZ) / 1000;
    localparam int TO_CYC  = (TO_RAW < 1) ? 1 : TO_RAW;
    localparam logic [FRAME_BITS-1:0] WR_WORD = {1'b1, CFG};
    localparam logic [FRAME_BITS-1:0] RD_WORD = '0;

    seq_state_t            st, st_nx;
    seq_status_t           status_q;
    logic                  busy_s;
    logic                  fr_go, fr_done;
    logic [FRAME_BITS-1:0] fr_word, rx_word;
    logic                  to_run, to_exp;
    logic                  gap_run, gap_exp;

    tconv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (busy_i),
        .q_o   (busy_s)
    );

    tconv_timer #(.LIMIT(TO_CYC)) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (to_run),
        .expired_o (to_exp)
    );

    tconv_timer #(.LIMIT(GAP_CYC)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (gap_run),
        .expired_o (gap_exp)
    );

    tconv_frame #(.DIV_W(DIV_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (fr_go),
        .word_i (fr_word),
        .div_i  (div_i),
        .dout_i (dout_i),
        .cs_n_o (cs_n_o),
        .sclk_o (sclk_o),
        .din_o  (din_o),
        .rx_o   (rx_word),
        .done_o (fr_done)
    );

    // next state
    always_comb begin
        st_nx   = st;
        fr_go   = 1'b0;
        fr_word = RD_WORD;
        to_run  = 1'b0;
        gap_run = 1'b0;
        unique case (st)
            S_IDLE: begin
                fr_word = WR_WORD;
                if (start_i && !busy_s) begin
                    fr_go = 1'b1;
                    st_nx = S_WRITE;
                end
            end
            S_WRITE: begin
                to_run = 1'b1;
                if (fr_done) st_nx = S_WAIT;
            end
            S_WAIT: begin
                to_run = 1'b1;
                if (!busy_s)     st_nx = S_GAP;
                else if (to_exp) st_nx = S_IDLE;
            end
            S_GAP: begin
                gap_run = 1'b1;
                if (gap_exp) begin
                    fr_go = 1'b1;
                    st_nx = S_READ;
                end
            end
            S_READ: begin
                if (fr_done) st_nx = S_IDLE;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            status_q <= ST_OK;
            tag_o    <= '0;
            value_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (st == S_WAIT && busy_s && to_exp) begin
                done_o   <= 1'b1;
                status_q <= ST_TIMEOUT;
            end else if (st == S_READ && fr_done) begin
                done_o <= 1'b1;
                if (&rx_word) begin
                    status_q <= ST_INVALID;
                end else begin
                    status_q <= ST_OK;
                    tag_o    <= rx_word[FRAME_BITS-1 -: TAG_BITS];
                    value_o  <= rx_word[VAL_BITS-1:0];
                end
            end
        end
    end

    assign status_o = status_q;

    // checker: cycles the synchronized busy has been low
    localparam int LW = $clog2(GAP_CYC + 1);
    logic [LW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      low_run <= '0;
        else if (busy_s)                 low_run <= '0;
        else if (low_run != LW'(GAP_CYC)) low_run <= low_run + 1'b1;
    end

    a_r4_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && $past(st) == S_GAP) |-> ($past(low_run) == LW'(GAP_CYC)));
    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT || st == S_GAP) |-> cs_n_o);
    a_r5_no_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && busy_s) |-> !din_o);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && busy_s && cs_n_o) |=> cs_n_o);
endmodule

// File: tb/tconv_seq_bench.sv
module tconv_seq_bench;
    localparam int CLK_PERIOD = 20;
    localparam int CLK_KHZ    = 50000;
    localparam int GAP_NS     = 100;
    localparam int TIMEOUT_US = 4;
    localparam int DIV_W      = 4;
    localparam int SYNC       = 2;
    localparam logic [14:0] CFG = 15'h0411;
    localparam int GAP_CYC    = (GAP_NS * CLK_KHZ + 999_999) / 1_000_000;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic done;
    logic [1:0] status;
    logic [3:0] tag;
    logic [11:0] value;
    logic cs_n, sclk, din;
    logic dout = 1'b0;
    logic busy = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // converter model state
    logic [15:0] resp = '0;
    logic [15:0] mdl_shift = '0;
    logic [15:0] cap_wr = '0;
    logic [15:0] cap_rd = '0;
    int bitptr = 15;
    int falls = 0;
    int last_fall = 0;
    int seq_frame = 0;
    int sclk_bad = 0;
    int cs_fall_cyc = 0;
    bit arm = 0;

    tconv_seq #(
        .CLK_KHZ(CLK_KHZ), .GAP_NS(GAP_NS), .TIMEOUT_US(TIMEOUT_US),
        .DIV_W(DIV_W), .SYNC_STAGES(SYNC), .CFG(CFG)
    ) u_tconv_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .div_i(div),
        .done_o(done), .status_o(status), .tag_o(tag), .value_o(value),
        .cs_n_o(cs_n), .sclk_o(sclk), .din_o(din), .dout_i(dout), .busy_i(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    always @(negedge cs_n) if (rst_n) begin
        cs_fall_cyc = cyc;
        mdl_shift = '0;
        falls = 0;
        bitptr = 15;
        dout = resp[15];
    end

    always @(negedge cs_n) if (rst_n && arm) begin
        arm = 0;
        #1 busy = 1'b1;
    end

    always @(negedge sclk) if (rst_n && !cs_n) begin
        mdl_shift = {mdl_shift[14:0], din};
        if (falls > 0 && (cyc - last_fall) != 2 * (int'(div) + 1)) sclk_bad++;
        last_fall = cyc;
        falls++;
        #1;
        if (bitptr > 0) begin
            bitptr--;
            dout = resp[bitptr];
        end
    end

    always @(posedge cs_n) if (rst_n) begin
        if (falls != 16) sclk_bad++;
        if (seq_frame == 0) cap_wr = mdl_shift;
        else                cap_rd = mdl_shift;
        seq_frame++;
    end

    always @(negedge clk) if (rst_n && cs_n && !sclk) sclk_bad++;

    always @(negedge clk) if (cyc > WDOG) begin
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WDOG);
        errors++;
        checks++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit got);
        int n = 0;
        got = 0;
        while (n < 4000 && !got) begin
            @(negedge clk);
            if (done) got = 1;
            n++;
        end
    endtask

    // one full sequence; mode 0 normal, 1 timeout
    task automatic run_seq(input int dv, input logic [15:0] rw, input int blen,
                           input bit poke, input bit tmo);
        int t0 = 0;
        int bad0;
        int tag_prev;
        int val_prev;
        bit got;
        bit inval;
        bad0 = sclk_bad;
        tag_prev = int'(tag);
        val_prev = int'(value);
        inval = (rw == 16'hFFFF);
        div = DIV_W'(dv);
        resp = rw;
        seq_frame = 0;
        arm = 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait (busy == 1'b1);
        if (!tmo) begin
            repeat (blen / 2) @(posedge clk);
            if (poke) begin
                @(negedge clk) start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
            repeat (blen / 2) @(posedge clk);
            #1 busy = 1'b0;
            t0 = cyc;
        end
        wait_done(got);
        chk(got, "R6 done seen", int'(got), 1);
        @(negedge clk);
        chk(!done, "R9 done one cycle", int'(done), 0);
        chk(cap_wr == {1'b1, CFG}, "R3 write word", int'(cap_wr), int'({1'b1, CFG}));
        chk(sclk_bad == bad0, "R2 frame shape", sclk_bad - bad0, 0);
        if (tmo) begin
            chk(status == 2'b01, "R8 timeout status", int'(status), 1);
            chk(seq_frame == 1, "R8 no read frame", seq_frame, 1);
            // R10: busy still high in idle, start must not launch a frame
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (40) @(negedge clk);
            chk(seq_frame == 1 && cs_n, "R10 start blocked by busy", seq_frame, 1);
            busy = 1'b0;
            repeat (10) @(negedge clk);
        end else begin
            chk(seq_frame == 2, "R9 frame count", seq_frame, 2);
            chk(cap_rd == 16'h0000, "R5 read word write bit", int'(cap_rd), 0);
            chk((cs_fall_cyc - t0) >= GAP_CYC && (cs_fall_cyc - t0) <= GAP_CYC + SYNC + 4,
                "R4 settling gap", cs_fall_cyc - t0, GAP_CYC);
            if (inval) begin
                chk(status == 2'b10, "R7 invalid status", int'(status), 2);
                chk(int'(tag) == tag_prev && int'(value) == val_prev, "R7 result held",
                    int'({tag, value}), (tag_prev << 12) | val_prev);
            end else begin
                chk(status == 2'b00, "R6 ok status", int'(status), 0);
                chk(tag == rw[15:12], "R6 tag", int'(tag), int'(rw[15:12]));
                chk(value == rw[11:0], "R6 value", int'(value), int'(rw[11:0]));
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk, "R1 idle bus", int'({cs_n, sclk}), 3);
        chk(!done && status == 2'b00, "R1 idle outputs", int'({done, status}), 0);
        for (int dv = 0; dv < 4; dv++) begin
            for (int k = 0; k < 5; k++) begin
                logic [15:0] w;
                w = {4'((k * 3 + dv) % 16), 12'((k * 837 + dv * 1111 + 5) % 4095)};
                run_seq(dv, w, 32 * (dv + 1) + 20, (k == 2), 1'b0);
            end
        end
        run_seq(1, 16'hFFFF, 84, 1'b0, 1'b0);
        run_seq(0, 16'h5A5A, 400, 1'b0, 1'b1);
        run_seq(2, 16'hC0DE, 116, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule